// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit With Y Register

This block runs integer multiplication and division for a processor that keeps a 32-bit Y register next to its general registers. A single `start_i` strobe launches one operation chosen by a 3-bit opcode. A multiply produces a 64-bit product: the upper word is returned on `y_o` for writing into Y, and the lower word is returned on `result_o` for the destination register. A divide treats `{y_i, opa_i}` as a 64-bit dividend and `opb_i` as the divisor, and returns a 32-bit quotient on `result_o`. Flag-setting variants also return N and Z updates, and flag-setting divides request that C and V be cleared.

The core is unsigned and shift-based. It produces one product bit per cycle over W cycles, or one quotient bit per cycle over 2W cycles. Signed operations first reduce the operands to magnitudes and apply the sign to the result at the end. A divide is refused with a trap before any computation starts in two cases: `div_off_i` is high (unimplemented trap), or the divisor is zero (divide-by-zero trap). The unimplemented trap takes priority.

The control FSM has five states:

| State | Role |
|---|---|
| `ST_IDLE` | Waiting for a start strobe |
| `ST_MUL` | Multiply iterations |
| `ST_DIV` | Divide iterations |
| `ST_FIX` | Sign correction and output registering |
| `ST_DONE` | One-cycle completion pulse |

| Transition | Condition |
|---|---|
| IDLE→DONE | Accepted start that traps |
| IDLE→MUL | Accepted multiply |
| IDLE→DIV | Accepted divide that does not trap |
| MUL→FIX | After the W-th step |
| DIV→FIX | After the 2W-th step |
| FIX→DONE | Always |
| DONE→IDLE | Always |

Top module: `muldiv_y_unit`

## Requirements
- R1: The opcode is decoded as follows: bit 2 selects divide (1) or multiply (0), bit 1 requests a flag update, and bit 0 selects signed arithmetic. A multiply returns the low 32 bits of the product on `result_o` with `rd_we_o`=1, and the high 32 bits on `y_o` with `y_we_o`=1.
- R2: A flag-setting multiply or divide that completes without a trap drives `flag_we_o`=1, `n_o` equal to bit 31 of `result_o`, and `z_o`=1 exactly when `result_o` is zero. Every other completion drives `flag_we_o`=0.
- R3: An unsigned divide returns the low 32 bits of `{y_i,opa_i} / opb_i` with `rd_we_o`=1 and `y_we_o`=0. A quotient wider than 32 bits is truncated and raises no overflow indication.
- R4: A divide with a zero divisor, while division is enabled, completes with `trap_div0_o`=1 and with `rd_we_o`, `y_we_o`, `flag_we_o` and `cv_clr_o` all 0.
- R5: While `div_off_i`=1, every divide opcode completes with `trap_unimp_o`=1 and `trap_div0_o`=0, even if the divisor is zero. Multiplies are unaffected.
- R6: A flag-setting divide without a trap drives `cv_clr_o`=1. All other completions drive `cv_clr_o`=0.
- R7: Signed operations return the two's-complement product, or the quotient truncated toward zero. Either result is taken to its low bits as in R1 and R3.
- R8: `start_i` is accepted only while `busy_o`=0. A start strobe while busy has no effect on the running operation. `done_o` is a single-cycle pulse.
- R9: Counted in clock cycles after the accepting edge, `done_o` is high at cycle 1 for a trapped divide, at cycle W+2 for a multiply, and at cycle 2W+2 for a divide.
- R10: After reset, `busy_o`, `done_o`, the write enables and both trap outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch strobe, sampled while idle |
| op_i | input | 3 | Opcode: [2] divide, [1] set flags, [0] signed |
| div_off_i | input | 1 | Division disabled; divides trap as unimplemented |
| opa_i | input | W | First operand; low dividend word for divides |
| opb_i | input | W | Second operand; divisor for divides |
| y_i | input | W | Current Y register; high dividend word |
| busy_o | output | 1 | Operation in progress, including the done cycle |
| done_o | output | 1 | Single-cycle completion pulse |
| result_o | output | W | Low product word or quotient |
| rd_we_o | output | 1 | Destination write request |
| y_o | output | W | New Y value |
| y_we_o | output | 1 | Y write request (multiplies only) |
| flag_we_o | output | 1 | N/Z update request |
| n_o | output | 1 | New N flag |
| z_o | output | 1 | New Z flag |
| cv_clr_o | output | 1 | Request to clear C and V |
| trap_unimp_o | output | 1 | Unimplemented-instruction trap |
| trap_div0_o | output | 1 | Divide-by-zero trap |

## Verification
An iteration counter that is off by one shifts the completion pulse away from cycle W+2 or 2W+2. It also leaves the product or quotient shifted by one bit, so the error is visible on `result_o` at the first completion. A wrong sign-correction latch or a stale opcode capture appears at the next done pulse as a negated result, a missing Y write, or a wrong trap. A mis-decoded trap shows up as `done_o` failing to rise on the first cycle after the strobe.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV,
        ST_FIX,
        ST_DONE
    } md_state_e;

    localparam int OP_SGN_BIT = 0;
    localparam int OP_CC_BIT  = 1;
    localparam int OP_DIV_BIT = 2;

    typedef struct packed {
        logic is_div;
        logic sets_cc;
        logic is_signed;
    } md_op_t;

endpackage

// File: rtl/muldiv_op_check.sv
module muldiv_op_check
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   op,
    input  logic         div_off,
    input  logic [W-1:0] divisor,
    output md_op_t       fields,
    output logic         trap_unimp,
    output logic         trap_div0
);
    always_comb begin
        fields.is_div    = op[OP_DIV_BIT];
        fields.sets_cc   = op[OP_CC_BIT];
        fields.is_signed = op[OP_SGN_BIT];
        // disabled division outranks the zero-divisor check
        trap_unimp = fields.is_div && div_off;
        trap_div0  = fields.is_div && !div_off && (divisor == '0);
    end
endmodule

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] prod
);
    logic [W-1:0] hi_q, lo_q, mc_q;
    logic [W:0]   sum;

    always_comb begin
        sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mc_q} : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
            mc_q <= '0;
        end else if (load) begin
            hi_q <= '0;
            lo_q <= mplier;
            mc_q <= mcand;
        end else if (step) begin
            hi_q <= sum[W:1];
            lo_q <= {sum[0], lo_q[W-1:1]};
        end
    end

    assign prod = {hi_q, lo_q};
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic [W-1:0]   quot
);
    logic [2*W-1:0] dvd_q;
    logic [W-1:0]   dvs_q, rem_q, q_q;
    logic [W:0]     trial;
    logic           fits;

    always_comb begin
        trial = {rem_q, dvd_q[2*W-1]};
        fits  = trial >= {1'b0, dvs_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q <= '0;
            dvs_q <= '0;
            rem_q <= '0;
            q_q   <= '0;
        end else if (load) begin
            dvd_q <= dividend;
            dvs_q <= divisor;
            rem_q <= '0;
            q_q   <= '0;
        end else if (step) begin
            dvd_q <= {dvd_q[2*W-2:0], 1'b0};
            rem_q <= fits ? W'(trial - {1'b0, dvs_q}) : trial[W-1:0];
            // older quotient bits fall off the top: truncation to W bits
            q_q   <= {q_q[W-2:0], fits};
        end
    end

    assign quot = q_q;
endmodule

// File: rtl/muldiv_y_unit.sv
module muldiv_y_unit
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [2:0]   op_i,
    input  logic         div_off_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [W-1:0] y_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o,
    output logic         rd_we_o,
    output logic [W-1:0] y_o,
    output logic         y_we_o,
    output logic         flag_we_o,
    output logic         n_o,
    output logic         z_o,
    output logic         cv_clr_o,
    output logic         trap_unimp_o,
    output logic         trap_div0_o
);
    localparam int DIV_STEPS = 2 * W;
    localparam int CNT_W     = $clog2(DIV_STEPS + 1);

    md_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    md_op_t         opf, op_q;
    logic           chk_unimp, chk_div0, trap_now, accept;
    logic           a_neg, b_neg, y_neg, neg_res, neg_q;
    logic [W-1:0]   a_mag, b_mag, y_q;
    logic [2*W-1:0] dvd, dvd_mag, prod, prod_fix;
    logic [W-1:0]   quot, quot_fix, fix_res;
    logic           mul_load, div_load, mul_step, div_step;
    logic           last_mul, last_div;

    muldiv_op_check #(.W(W)) u_check (
        .op         (op_i),
        .div_off    (div_off_i),
        .divisor    (opb_i),
        .fields     (opf),
        .trap_unimp (chk_unimp),
        .trap_div0  (chk_div0)
    );

    always_comb begin
        accept   = start_i && (state_q == ST_IDLE);
        trap_now = chk_unimp || chk_div0;
        a_neg    = opf.is_signed && opa_i[W-1];
        b_neg    = opf.is_signed && opb_i[W-1];
        y_neg    = opf.is_signed && y_i[W-1];
        a_mag    = a_neg ? -opa_i : opa_i;
        b_mag    = b_neg ? -opb_i : opb_i;
        dvd      = {y_i, opa_i};
        dvd_mag  = y_neg ? -dvd : dvd;
        neg_res  = opf.is_div ? (y_neg ^ b_neg) : (a_neg ^ b_neg);
        mul_load = accept && !opf.is_div;
        div_load = accept && opf.is_div && !trap_now;
        mul_step = (state_q == ST_MUL);
        div_step = (state_q == ST_DIV);
        last_mul = (cnt_q == CNT_W'(W - 1));
        last_div = (cnt_q == CNT_W'(DIV_STEPS - 1));
    end

    muldiv_mul_core #(.W(W)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mul_load),
        .step   (mul_step),
        .mcand  (a_mag),
        .mplier (b_mag),
        .prod   (prod)
    );

    muldiv_div_core #(.W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .step     (div_step),
        .dividend (dvd_mag),
        .divisor  (b_mag),
        .quot     (quot)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                cnt_q <= '0;
            else if (mul_step || div_step)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (trap_now)        state_d = ST_DONE;
                    else if (opf.is_div) state_d = ST_DIV;
                    else                 state_d = ST_MUL;
                end
            end
            ST_MUL:  if (last_mul) state_d = ST_FIX;
            ST_DIV:  if (last_div) state_d = ST_FIX;
            ST_FIX:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- operand capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            neg_q <= 1'b0;
            y_q   <= '0;
        end else if (accept) begin
            op_q  <= opf;
            neg_q <= neg_res;
            y_q   <= y_i;
        end
    end

    always_comb begin
        prod_fix = neg_q ? -prod : prod;
        quot_fix = neg_q ? -quot : quot;
        fix_res  = op_q.is_div ? quot_fix : prod_fix[W-1:0];
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o     <= '0;
            y_o          <= '0;
            rd_we_o      <= 1'b0;
            y_we_o       <= 1'b0;
            flag_we_o    <= 1'b0;
            n_o          <= 1'b0;
            z_o          <= 1'b0;
            cv_clr_o     <= 1'b0;
            trap_unimp_o <= 1'b0;
            trap_div0_o  <= 1'b0;
        end else if (accept) begin
            rd_we_o      <= 1'b0;
            y_we_o       <= 1'b0;
            flag_we_o    <= 1'b0;
            n_o          <= 1'b0;
            z_o          <= 1'b0;
            cv_clr_o     <= 1'b0;
            trap_unimp_o <= chk_unimp;
            trap_div0_o  <= chk_div0;
        end else if (state_q == ST_FIX) begin
            result_o  <= fix_res;
            rd_we_o   <= 1'b1;
            flag_we_o <= op_q.sets_cc;
            n_o       <= op_q.sets_cc && fix_res[W-1];
            z_o       <= op_q.sets_cc && (fix_res == '0);
            cv_clr_o  <= op_q.is_div && op_q.sets_cc;
            y_we_o    <= !op_q.is_div;
            y_o       <= op_q.is_div ? y_q : prod_fix[2*W-1:W];
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_DONE);

endmodule

// File: rtl/muldiv_y_checker.sv
module muldiv_y_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [2:0]   op_i,
    input logic         div_off_i,
    input logic [W-1:0] opb_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] result_o,
    input logic         rd_we_o,
    input logic         y_we_o,
    input logic         flag_we_o,
    input logic         n_o,
    input logic         z_o,
    input logic         cv_clr_o,
    input logic         trap_unimp_o,
    input logic         trap_div0_o
);
    logic c_div, c_cc, c_off, c_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_div  <= 1'b0;
            c_cc   <= 1'b0;
            c_off  <= 1'b0;
            c_zero <= 1'b0;
        end else if (start_i && !busy_o) begin
            c_div  <= op_i[2];
            c_cc   <= op_i[1];
            c_off  <= div_off_i;
            c_zero <= (opb_i == '0);
        end
    end

    p_mul_writes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !c_div |-> y_we_o && rd_we_o && !trap_unimp_o && !trap_div0_o);

    p_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && flag_we_o |-> (n_o == result_o[W-1]) && (z_o == (result_o == '0)));

    p_div_no_y_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && c_div |-> !y_we_o);

    p_div0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && c_div && !c_off && c_zero |->
            trap_div0_o && !rd_we_o && !flag_we_o && !cv_clr_o);

    p_unimp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && c_div && c_off |-> trap_unimp_o && !trap_div0_o && !rd_we_o);

    p_cv_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !trap_unimp_o && !trap_div0_o |-> (cv_clr_o == (c_div && c_cc)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> busy_o);

    p_trap_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && op_i[2] && (div_off_i || opb_i == '0) |=>
            done_o && (trap_unimp_o || trap_div0_o));
endmodule

bind muldiv_y_unit muldiv_y_checker #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .op_i         (op_i),
    .div_off_i    (div_off_i),
    .opb_i        (opb_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .rd_we_o      (rd_we_o),
    .y_we_o       (y_we_o),
    .flag_we_o    (flag_we_o),
    .n_o          (n_o),
    .z_o          (z_o),
    .cv_clr_o     (cv_clr_o),
    .trap_unimp_o (trap_unimp_o),
    .trap_div0_o  (trap_div0_o)
);

// File: tb/muldiv_y_unit_bench.sv
module muldiv_y_unit_bench;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [2:0]    op_i = '0;
    logic          div_off_i = 1'b0;
    logic [W-1:0]  opa_i = '0, opb_i = '0, y_i = '0;
    logic          busy_o, done_o, rd_we_o, y_we_o, flag_we_o, n_o, z_o;
    logic          cv_clr_o, trap_unimp_o, trap_div0_o;
    logic [W-1:0]  result_o, y_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    muldiv_y_unit #(.W(W)) u_muldiv_y_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .div_off_i(div_off_i), .opa_i(opa_i), .opb_i(opb_i), .y_i(y_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .rd_we_o(rd_we_o), .y_o(y_o), .y_we_o(y_we_o),
        .flag_we_o(flag_we_o), .n_o(n_o), .z_o(z_o), .cv_clr_o(cv_clr_o),
        .trap_unimp_o(trap_unimp_o), .trap_div0_o(trap_div0_o)
    );

    typedef struct {
        logic        unimp, div0, rd_we, y_we, flag_we, n, z, cv;
        logic [31:0] res, y;
        int          lat;
    } exp_t;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [2:0] op, input logic [31:0] a,
                                   input logic [31:0] b, input logic [31:0] y,
                                   input logic off);
        exp_t e;
        logic [63:0] p, d, dm, qm;
        logic [31:0] bm;
        e = '{default: '0};
        e.y = y;
        if (op[2] && off) begin
            e.unimp = 1'b1; e.lat = 1;
        end else if (op[2] && b == 0) begin
            e.div0 = 1'b1; e.lat = 1;
        end else begin
            e.rd_we = 1'b1;
            if (!op[2]) begin
                if (op[0]) p = 64'(longint'($signed(a)) * longint'($signed(b)));
                else       p = 64'(a) * 64'(b);
                e.res = p[31:0]; e.y = p[63:32]; e.y_we = 1'b1; e.lat = W + 2;
            end else begin
                d = {y, a};
                if (!op[0]) qm = d / 64'(b);
                else begin
                    dm = y[31] ? -d : d;
                    bm = b[31] ? -b : b;
                    qm = dm / 64'(bm);
                    if (y[31] ^ b[31]) qm = -qm;
                end
                e.res = qm[31:0]; e.lat = 2 * W + 2; e.cv = op[1];
            end
            e.flag_we = op[1];
            e.n = op[1] && e.res[31];
            e.z = op[1] && (e.res == 0);
        end
        return e;
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] y,
                          input logic off, input bit inject);
        exp_t e;
        int lat;
        e = model(op, a, b, y, off);
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b; y_i = y; div_off_i = off; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 300) begin
            if (inject && lat == 4) begin
                // R8: a second strobe while busy, carrying a trapping divide
                start_i = 1'b1; op_i = 3'b100; opb_i = '0; div_off_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        check(lat == e.lat, "R9 latency", 64'(lat), 64'(e.lat));
        check(trap_unimp_o == e.unimp, "R5 trap_unimp", 64'(trap_unimp_o), 64'(e.unimp));
        check(trap_div0_o == e.div0, "R4 trap_div0", 64'(trap_div0_o), 64'(e.div0));
        check(rd_we_o == e.rd_we, "R1 rd_we", 64'(rd_we_o), 64'(e.rd_we));
        check(y_we_o == e.y_we, "R3 y_we", 64'(y_we_o), 64'(e.y_we));
        check(flag_we_o == e.flag_we, "R2 flag_we", 64'(flag_we_o), 64'(e.flag_we));
        check(cv_clr_o == e.cv, "R6 cv_clr", 64'(cv_clr_o), 64'(e.cv));
        if (e.rd_we) begin
            check(result_o == e.res, op[0] ? "R7 signed result" : "R1 R3 result",
                  64'(result_o), 64'(e.res));
            if (e.flag_we) begin
                check(n_o == e.n, "R2 n flag", 64'(n_o), 64'(e.n));
                check(z_o == e.z, "R2 z flag", 64'(z_o), 64'(e.z));
            end
        end
        if (e.y_we) check(y_o == e.y, "R1 y high word", 64'(y_o), 64'(e.y));
        @(negedge clk);
        check(!done_o && !busy_o, "R8 done single pulse", 64'({done_o, busy_o}), 64'(0));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!busy_o && !done_o, "R10 reset busy/done", 64'({busy_o, done_o}), 64'(0));
        check(!rd_we_o && !y_we_o && !trap_unimp_o && !trap_div0_o, "R10 reset enables",
              64'({rd_we_o, y_we_o, trap_unimp_o, trap_div0_o}), 64'(0));
        rst_n = 1'b1;

        // directed corners
        run_op(3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0);   // R1
        run_op(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0);   // R7 -1*-1
        run_op(3'b011, 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b0, 1'b0);   // R7
        run_op(3'b010, 32'h0001_0000, 32'h0001_0000, 32'h0, 1'b0, 1'b0);   // R2 Z from low word
        run_op(3'b001, 32'h0000_0007, 32'hFFFF_FFFD, 32'h0, 1'b1, 1'b0);   // R5 mul unaffected
        run_op(3'b110, 32'h0000_0000, 32'h0000_0001, 32'h5, 1'b0, 1'b0);   // R3 truncation, Z
        run_op(3'b100, 32'h1234_5678, 32'h0000_0000, 32'h9, 1'b0, 1'b0);   // R4
        run_op(3'b111, 32'h1234_5678, 32'h0000_0000, 32'h9, 1'b1, 1'b0);   // R5 priority
        run_op(3'b111, 32'hFFFF_FFF9, 32'h0000_0002, 32'hFFFF_FFFF, 1'b0, 1'b0); // R7 -7/2=-3
        run_op(3'b101, 32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b0); // R7 extreme
        run_op(3'b110, 32'hDEAD_BEEF, 32'h0001_0000, 32'h0000_0003, 1'b0, 1'b0); // R6
        run_op(3'b010, 32'h0000_0123, 32'h0000_0456, 32'h0, 1'b0, 1'b1);   // R8 ignored start
        run_op(3'b100, 32'h0000_0064, 32'h0000_0007, 32'h0, 1'b0, 1'b1);   // R8 during divide

        // constrained random
        for (int i = 0; i < 250; i++) begin
            logic [2:0]  op;
            logic [31:0] a, b, y;
            logic        off;
            op  = 3'($urandom % 8);
            a   = $urandom;
            b   = $urandom;
            y   = $urandom;
            off = ($urandom % 8) == 0;
            if (($urandom % 16) == 0) b = '0;
            else if (($urandom % 4) == 0) b = b & 32'h0000_00FF;
            if (($urandom % 3) == 0) y = y & 32'h0000_000F;
            run_op(op, a, b, y, off, ($urandom % 10) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule